// File: doc/BRIEF.md
# Press-Toggle Matrix Scanner

This block services an 8x8 grid of press-sensitive crossings. It energises one row line at a time, reads the eight column sense lines for that row, and keeps a 64-bit on/off picture. Each pixel acts as a push-on/push-off switch. A fresh press flips the pixel's state. A press that is still held on the next visit to its row does nothing, because the block stores one "was pressed" bit for every pixel.

The scan runs without stopping. Each row stays selected for a fixed number of clock cycles (the dwell), and its columns are sampled on the last cycle of that dwell. Rows are visited from row 0 up to the last row, and then the scan wraps. A one-cycle pulse marks the end of each complete pass. While the mode input is high, toggling is suspended: the picture follows an external load port and all press history is cleared. When the mode returns low, the block goes back to press-driven toggling.

Top module: `pts_matrix_scanner`

## Requirements
- R1: During and directly after an active-low reset, `pixels` is all zero, `row_drive` selects row 0 (value 8'b0000_0001), and `scan_done` is low.
- R2: `row_drive` is one-hot with bit k selecting row k. Each row stays selected for exactly DWELL cycles, and rows follow the order 0, 1, ..., ROWS-1, 0, ...
- R3: `scan_done` is high for exactly one cycle in every ROWS*DWELL cycles. That cycle directly follows the sample of the last row, and in it `row_drive` already selects row 0.
- R4: With mode low, a new press on a pixel that is off turns it on, and a new press on a pixel that is on turns it off. Between samples, `pixels` does not change.
- R5: A press held over several passes toggles its pixel only once. Releasing it clears that pixel's history, so the next press toggles the pixel again.
- R6: Columns are sampled on the last dwell cycle of the selected row. Column input bit c (1 = pressed) during row r affects `pixels` bit r*COLS+c. The result is visible from the next cycle.
- R7: While mode is high, `pixels` equals the value `load_pixels` had one cycle earlier, and column presses have no effect on it.
- R8: Mode high clears all press history. A press held across the return to mode low therefore toggles its pixel at the first sample of its row.
- R9: Pixels toggle independently. Several new presses in one row toggle all of those pixels in the same sample, and presses in different rows each toggle their own pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | 1 = load picture from `load_pixels`; 0 = press toggling |
| load_pixels | input | ROWS*COLS | Picture to load, row r in bits [r*COLS +: COLS] |
| col_sense | input | COLS | Column sense lines for the selected row, 1 = pressed |
| row_drive | output | ROWS | One-hot row select |
| pixels | output | ROWS*COLS | Pixel state, row r in bits [r*COLS +: COLS], bit c = column c |
| scan_done | output | 1 | One-cycle pulse after each full pass |

## Verification
A behavioural model with its own row and dwell counters and per-pixel arrays is compared against the design on every cycle. The stimulus covers five cases, each aimed at a different fault:
- A single press held over three passes separates edge detection from level toggling.
- Releasing and pressing again shows that the history clears on release and that the on-to-off direction works.
- Presses in two columns of one row, together with one press in another row, expose column or row mapping faults and toggles that do not stay independent.
- A load with every column pressed shows that presses are ignored in load mode.
- Keeping one press held across the switch back to toggle mode shows that the load cleared the press history.

// File: rtl/pts_pkg.sv
package pts_pkg;

  // Next index of a counter that wraps at lim.
  function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction

  // Number of bits needed to hold the values 0..n-1 (at least 1).
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pts_scan_seq.sv
module pts_scan_seq
  import pts_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int DWELL = 4,
  localparam int ROW_W = idx_bits(ROWS),
  localparam int DW_W  = idx_bits(DWELL)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [ROWS-1:0]  row_drive,
  output logic [ROW_W-1:0] row_idx,
  output logic             sample,
  output logic             pass_end
);

  logic [ROW_W-1:0] row_q;
  logic [DW_W-1:0]  dw_q;

  assign row_idx  = row_q;
  assign sample   = (dw_q == DW_W'(DWELL - 1));
  assign pass_end = sample && (row_q == ROW_W'(ROWS - 1));

  always_comb begin
    row_drive        = '0;
    row_drive[row_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      dw_q  <= '0;
    end else if (sample) begin
      dw_q  <= '0;
      row_q <= ROW_W'(wrap_inc(int'(row_q), ROWS));
    end else begin
      dw_q  <= dw_q + DW_W'(1);
    end
  end

  // R2: the row select holds until a sample, then moves up by one row or wraps to row 0
  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(row_drive));
  assert_row_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !row_drive[ROWS-1]) |=> (row_drive == ($past(row_drive) << 1)));
  assert_row_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && row_drive[ROWS-1]) |=> row_drive[0]);

endmodule

// File: rtl/pts_press_edge.sv
module pts_press_edge
  import pts_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = idx_bits(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             sample,
  input  logic [ROW_W-1:0] row_idx,
  input  logic [COLS-1:0]  col_sense,
  output logic [COLS-1:0]  rise
);

  // One history bit per pixel: set while that pixel was seen pressed at its last sample.
  logic [COLS-1:0] seen_q [ROWS];

  function automatic logic [COLS-1:0] new_press(input logic [COLS-1:0] now_pressed,
                                                input logic [COLS-1:0] was_pressed);
    return now_pressed & ~was_pressed;
  endfunction

  assign rise = new_press(col_sense, seen_q[row_idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) seen_q[r] <= '0;
    end else if (mode) begin
      for (int r = 0; r < ROWS; r++) seen_q[r] <= '0;
    end else if (sample) begin
      seen_q[row_idx] <= col_sense;
    end
  end

  // R8: once a load cycle has passed, every pressed column counts as a new press
  assert_hist_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> (rise == col_sense));

endmodule

// File: rtl/pts_pixel_store.sv
module pts_pixel_store
  import pts_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  localparam int ROW_W = idx_bits(ROWS),
  localparam int NPIX  = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode,
  input  logic             sample,
  input  logic [ROW_W-1:0] row_idx,
  input  logic [COLS-1:0]  rise,
  input  logic [NPIX-1:0]  load_pixels,
  output logic [NPIX-1:0]  pixels
);

  logic [COLS-1:0] pix_q [ROWS];

  function automatic logic [COLS-1:0] flip_row(input logic [COLS-1:0] cur,
                                               input logic [COLS-1:0] hits);
    return cur ^ hits;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) pix_q[r] <= '0;
    end else if (mode) begin
      for (int r = 0; r < ROWS; r++) pix_q[r] <= load_pixels[r*COLS +: COLS];
    end else if (sample) begin
      pix_q[row_idx] <= flip_row(pix_q[row_idx], rise);
    end
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_out
    assign pixels[g*COLS +: COLS] = pix_q[g];
  end

  // R7: in load mode the picture follows the load port one cycle later
  assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode |=> (pixels == $past(load_pixels)));
  // R4: with mode low, the picture changes only at a sample
  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && !sample) |=> $stable(pixels));
  // R9: a sample flips exactly as many pixels as there were new presses
  assert_flip_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode && sample) |=> ($countones(pixels ^ $past(pixels)) == $countones($past(rise))));

endmodule

// File: rtl/pts_matrix_scanner.sv
module pts_matrix_scanner
  import pts_pkg::*;
#(
  parameter int ROWS  = 8,
  parameter int COLS  = 8,
  parameter int DWELL = 4,
  localparam int ROW_W = idx_bits(ROWS),
  localparam int NPIX  = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode,
  input  logic [NPIX-1:0] load_pixels,
  input  logic [COLS-1:0] col_sense,
  output logic [ROWS-1:0] row_drive,
  output logic [NPIX-1:0] pixels,
  output logic            scan_done
);

  logic [ROW_W-1:0] row_idx;
  logic             sample;
  logic             pass_end;
  logic [COLS-1:0]  rise;

  pts_scan_seq #(.ROWS(ROWS), .DWELL(DWELL)) u_seq (
    .clk(clk), .rst_n(rst_n), .row_drive(row_drive), .row_idx(row_idx),
    .sample(sample), .pass_end(pass_end)
  );

  pts_press_edge #(.ROWS(ROWS), .COLS(COLS)) u_edge (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sample(sample), .row_idx(row_idx),
    .col_sense(col_sense), .rise(rise)
  );

  pts_pixel_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sample(sample), .row_idx(row_idx),
    .rise(rise), .load_pixels(load_pixels), .pixels(pixels)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scan_done <= 1'b0;
    else        scan_done <= pass_end;
  end

  // R3: the end-of-pass marker lasts one cycle and comes when row 0 is selected again
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
  assert_done_row0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> row_drive[0]);

endmodule

// File: tb/tb_pts_matrix_scanner.sv
module tb_pts_matrix_scanner;
  localparam int ROWS  = 8;
  localparam int COLS  = 8;
  localparam int DWELL = 4;
  localparam int NPIX  = ROWS * COLS;
  localparam int PASS  = ROWS * DWELL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode = 1'b0;
  logic [NPIX-1:0] load_pixels = '0;
  logic [NPIX-1:0] presses = '0;
  logic [COLS-1:0] col_sense;
  logic [ROWS-1:0] row_drive;
  logic [NPIX-1:0] pixels;
  logic scan_done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pts_matrix_scanner #(.ROWS(ROWS), .COLS(COLS), .DWELL(DWELL)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .load_pixels(load_pixels),
    .col_sense(col_sense), .row_drive(row_drive), .pixels(pixels), .scan_done(scan_done)
  );

  // Simulated grid: the columns show the pressed crossings of the row being driven.
  always_comb begin
    col_sense = '0;
    for (int r = 0; r < ROWS; r++)
      if (row_drive[r]) col_sense = col_sense | presses[r*COLS +: COLS];
  end

  task automatic check(input string tag, input logic [NPIX-1:0] act, input logic [NPIX-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_row;
  int m_dw;
  bit m_pix  [NPIX];
  bit m_seen [NPIX];
  bit m_done;
  bit m_smp;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_row = 0; m_dw = 0; m_done = 0;
      for (int i = 0; i < NPIX; i++) begin m_pix[i] = 0; m_seen[i] = 0; end
    end else begin
      m_smp  = (m_dw == DWELL - 1);
      m_done = m_smp && (m_row == ROWS - 1);
      if (mode) begin
        for (int i = 0; i < NPIX; i++) begin m_pix[i] = load_pixels[i]; m_seen[i] = 0; end
      end else if (m_smp) begin
        for (int c = 0; c < COLS; c++) begin
          if (col_sense[c] && !m_seen[m_row*COLS + c]) m_pix[m_row*COLS + c] = !m_pix[m_row*COLS + c];
          m_seen[m_row*COLS + c] = col_sense[c];
        end
      end
      if (m_smp) begin m_dw = 0; m_row = (m_row + 1) % ROWS; end
      else m_dw++;
    end
  end

  function automatic logic [NPIX-1:0] model_pix();
    logic [NPIX-1:0] v;
    for (int i = 0; i < NPIX; i++) v[i] = m_pix[i];
    return v;
  endfunction

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 row_drive", NPIX'(row_drive), NPIX'(1) << m_row);
      check("R3 scan_done", NPIX'(scan_done), NPIX'(m_done));
      check("R4 pixels vs model", pixels, model_pix());
    end
  end

  task automatic passes(input int n);
    repeat (n * PASS) @(negedge clk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset pixels", pixels, '0);
    check("R1 reset row_drive", NPIX'(row_drive), NPIX'(1));
    check("R1 reset scan_done", NPIX'(scan_done), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release pixels", pixels, '0);

    // R4 R5: a held press toggles once
    presses[2*COLS + 5] = 1'b1;
    passes(3);
    check("R5 held press toggles once", pixels, NPIX'(1) << 21);
    presses = '0;
    passes(1);
    check("R5 release keeps state", pixels, NPIX'(1) << 21);
    presses[2*COLS + 5] = 1'b1;
    passes(2);
    check("R4 second press turns off", pixels, '0);
    presses = '0;
    passes(1);

    // R6 R9: several columns in one row and a press in another row
    presses[3*COLS + 0] = 1'b1;
    presses[3*COLS + 7] = 1'b1;
    presses[6*COLS + 4] = 1'b1;
    passes(1);
    check("R9 R6 independent toggles", pixels, (NPIX'(1) << 24) | (NPIX'(1) << 31) | (NPIX'(1) << 52));
    presses = '0;
    passes(1);

    // R7: load overrides the picture and presses are ignored
    mode = 1'b1;
    load_pixels = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    check("R7 load applied", pixels, 64'h0123_4567_89AB_CDEF);
    presses = '1;
    passes(1);
    check("R7 presses ignored in load mode", pixels, 64'h0123_4567_89AB_CDEF);

    // R8: press held across the return to toggle mode still toggles
    presses = '0;
    presses[0] = 1'b1;
    mode = 1'b0;
    passes(1);
    check("R8 history cleared by load", pixels, 64'h0123_4567_89AB_CDEE);
    passes(1);
    check("R5 held after load no retoggle", pixels, 64'h0123_4567_89AB_CDEE);
    presses = '0;
    passes(1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule